// File: doc/BRIEF.md
# Inbound Memory Window Decoder

This block sits on the inbound path of a bus bridge. It holds three programmable memory windows and checks each incoming 32-bit bus address against them. When an address lands in a window, the block reports a hit and the number of the window. It also gives the local address, which is the byte offset inside that window, because every window maps onto local memory starting at zero.

Each window is set by one 32-bit register. Bits 31..20 hold a base at 1 MB granularity. Bits 19..16 hold a size code n, which selects a window of 2^(20+n) bytes. Codes 0..11 cover 1 MB to 2 GB, and codes 12..15 disable the window. Only the part of the base above the window size takes part in the compare. The hit, window index and translated address are registered, so they appear one clock after the address strobe.

Top module: `inbound_window_decoder`

## Requirements
- R1: After reset, every window register reads 0x000F0000 (base 0, size code 0xF, which is disabled), and no address hits.
- R2: A write to a window register keeps data bits 31..20 as the base and bits 19..16 as the size code. A read returns exactly those fields, and bits 15..0 read as zero.
- R3: The window registers sit at byte offsets 0x50, 0x54 and 0x58 for windows 0, 1 and 2. A write to any other offset changes no window, and a read of any other offset returns zero.
- R4: An address hits window k when its bits 31..(20+n) equal the same bits of that window's base, where n is the window's size code. Base bits below 20+n have no effect.
- R5: On a hit, the translated address equals the bus address modulo 2^(20+n) of the winning window.
- R6: A window whose size code is 12, 13, 14 or 15 never hits.
- R7: When several windows hit, the lowest-numbered window is reported.
- R8: hit_o, win_idx_o and xlat_addr_o reflect the address presented with addr_valid_i in the previous clock. If addr_valid_i was low in the previous clock, hit_o is low.
- R9: Whenever hit_o is low, win_idx_o and xlat_addr_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register byte offset |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational) |
| addr_valid_i | input | 1 | Bus address strobe |
| bus_addr_i | input | 32 | Incoming bus address |
| hit_o | output | 1 | Address hit a window (registered) |
| win_idx_o | output | 2 | Number of the winning window |
| xlat_addr_o | output | 32 | Translated local address |

## Verification
Several properties are checked by assertions on every cycle. A disabled code never produces a window hit. The priority grant is at most one-hot and always points at a hitting window. Outputs stay low and zero after a cycle without a strobe or without a hit. Register writes capture the base and code only at the selected offset.

Other behaviour can only be shown by the bench scenarios, which compare the outputs against a reference model. This covers the exact window edges at the last byte and one byte past it, and masking of base bits below the window size. It also covers the 2 GB window, overlapping windows resolved by index, and the offset arithmetic.

// File: rtl/iwd_pkg.sv
package iwd_pkg;
  localparam int ADDR_W   = 32;
  localparam int BASE_LSB = 20;
  localparam int CODE_W   = 4;
  localparam int CODE_LSB = 16;
  localparam int BASE_W   = ADDR_W - BASE_LSB;
  localparam int MAX_CODE = 11;
  localparam int SH_W     = $clog2(ADDR_W) + 1;
  localparam logic [CODE_W-1:0] DIS_CODE = '1;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [CODE_W-1:0] code;
  } win_cfg_t;
endpackage

// File: rtl/iwd_regs.sv
module iwd_regs
  import iwd_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int CFG_AW  = 8,
  parameter int REG_BASE = 'h50
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [CFG_AW-1:0]     cfg_addr_i,
  input  logic [ADDR_W-1:0]     cfg_wdata_i,
  output logic [ADDR_W-1:0]     cfg_rdata_o,
  output win_cfg_t              cfg_o [NUM_WIN]
);
  logic [NUM_WIN-1:0] sel;
  win_cfg_t cfg_q [NUM_WIN];
  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata_i[CODE_LSB-1:0];

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    assign sel[k] = (cfg_addr_i == CFG_AW'(REG_BASE + 4 * k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[k].base <= '0;
        cfg_q[k].code <= DIS_CODE;
      end else if (cfg_we_i && sel[k]) begin
        cfg_q[k].base <= cfg_wdata_i[ADDR_W-1:BASE_LSB];
        cfg_q[k].code <= cfg_wdata_i[CODE_LSB +: CODE_W];
      end
    end
    assign cfg_o[k] = cfg_q[k];

    // R2
    wr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_we_i && sel[k] |=> cfg_q[k].base == $past(cfg_wdata_i[ADDR_W-1:BASE_LSB])
                          && cfg_q[k].code == $past(cfg_wdata_i[CODE_LSB +: CODE_W]));
    // R3
    wr_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cfg_we_i && sel[k]) |=> $stable(cfg_q[k]));
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int k = 0; k < NUM_WIN; k++) begin
      if (sel[k]) cfg_rdata_o = {cfg_q[k].base, cfg_q[k].code, {CODE_LSB{1'b0}}};
    end
  end
endmodule

// File: rtl/iwd_match.sv
module iwd_match
  import iwd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  win_cfg_t          cfg_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] off_o
);
  logic [SH_W-1:0]   sz_log;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] base_full;
  logic              en;

  assign en        = (cfg_i.code <= CODE_W'(MAX_CODE));
  assign sz_log    = SH_W'(BASE_LSB) + SH_W'(cfg_i.code);
  assign mask      = {ADDR_W{1'b1}} << sz_log;   // upper compare bits
  assign base_full = {cfg_i.base, {BASE_LSB{1'b0}}};
  assign hit_o     = en && (((addr_i ^ base_full) & mask) == '0);
  assign off_o     = addr_i & ~mask;

  always_comb begin
    // R6
    if (cfg_i.code > CODE_W'(MAX_CODE))
      disabled_no_hit_chk: assert (!hit_o);
  end
endmodule

// File: rtl/iwd_select.sv
module iwd_select
  import iwd_pkg::*;
#(
  parameter int NUM_WIN = 3,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [NUM_WIN-1:0] hit_i,
  input  logic [ADDR_W-1:0]  off_i [NUM_WIN],
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [ADDR_W-1:0]  off_o
);
  logic [NUM_WIN-1:0] gnt;
  assign gnt   = hit_i & (~hit_i + NUM_WIN'(1));
  assign any_o = |hit_i;

  always_comb begin
    idx_o = '0;
    off_o = '0;
    for (int k = NUM_WIN - 1; k >= 0; k--) begin
      if (hit_i[k]) begin
        idx_o = IDX_W'(k);
        off_o = off_i[k];
      end
    end
  end

  always_comb begin
    // R7
    gnt_onehot_chk: assert ($onehot0(gnt));
    // R7
    if (any_o) gnt_idx_chk: assert (gnt[idx_o] && hit_i[idx_o]);
  end
endmodule

// File: rtl/inbound_window_decoder.sv
module inbound_window_decoder
  import iwd_pkg::*;
#(
  parameter int NUM_WIN  = 3,
  parameter int CFG_AW   = 8,
  parameter int REG_BASE = 'h50,
  localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic [ADDR_W-1:0] cfg_rdata_o,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  win_idx_o,
  output logic [ADDR_W-1:0] xlat_addr_o
);
  win_cfg_t           cfg [NUM_WIN];
  logic [NUM_WIN-1:0] hit_vec;
  logic [ADDR_W-1:0]  off_vec [NUM_WIN];
  logic               any_hit;
  logic [IDX_W-1:0]   sel_idx;
  logic [ADDR_W-1:0]  sel_off;

  iwd_regs #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW), .REG_BASE(REG_BASE)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .cfg_o(cfg)
  );

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_match
    iwd_match u_match (
      .addr_i(bus_addr_i), .cfg_i(cfg[k]), .hit_o(hit_vec[k]), .off_o(off_vec[k])
    );
  end

  iwd_select #(.NUM_WIN(NUM_WIN)) u_select (
    .hit_i(hit_vec), .off_i(off_vec), .any_o(any_hit), .idx_o(sel_idx), .off_o(sel_off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o       <= 1'b0;
      win_idx_o   <= '0;
      xlat_addr_o <= '0;
    end else if (addr_valid_i && any_hit) begin
      hit_o       <= 1'b1;
      win_idx_o   <= sel_idx;
      xlat_addr_o <= sel_off;
    end else begin
      hit_o       <= 1'b0;
      win_idx_o   <= '0;
      xlat_addr_o <= '0;
    end
  end

  // R8
  no_strobe_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_i |=> !hit_o);
  // R9
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (win_idx_o == '0) && (xlat_addr_o == '0));
  // R4
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> int'(win_idx_o) < NUM_WIN);
endmodule

// File: tb/inbound_window_decoder_bench.sv
module inbound_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        addr_valid_i = 1'b0;
  logic [31:0] bus_addr_i = '0;
  logic        hit_o;
  logic [1:0]  win_idx_o;
  logic [31:0] xlat_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mdl [3];
  bit done = 0;

  always #4 clk = ~clk;

  inbound_window_decoder u_inbound_window_decoder (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .addr_valid_i, .bus_addr_i, .hit_o, .win_idx_o, .xlat_addr_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, output bit h, output logic [1:0] i,
                                output logic [31:0] x);
    h = 0; i = 0; x = 0;
    for (int k = 2; k >= 0; k--) begin
      int n;
      logic [31:0] m;
      n = int'(mdl[k][19:16]);
      if (n <= 11) begin
        m = 32'hFFFF_FFFF << (20 + n);
        if (((a ^ {mdl[k][31:20], 20'h0}) & m) == 0) begin
          h = 1; i = 2'(k); x = a & ~m;
        end
      end
    end
  endfunction

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1; cfg_addr_i = off; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 0;
    for (int k = 0; k < 3; k++)
      if (off == 8'(8'h50 + 4 * k)) mdl[k] = d & 32'hFFFF_0000;
  endtask

  task automatic rd(input logic [7:0] off, input string req);
    logic [31:0] e;
    e = 0;
    for (int k = 0; k < 3; k++)
      if (off == 8'(8'h50 + 4 * k)) e = mdl[k];
    cfg_addr_i = off;
    #1;
    chk(cfg_rdata_o === e, req, cfg_rdata_o, e);
  endtask

  task automatic probe(input logic [31:0] a, input bit v, input string req);
    bit h; logic [1:0] i; logic [31:0] x;
    @(negedge clk);
    bus_addr_i = a; addr_valid_i = v;
    model(a, h, i, x);
    if (!v) begin h = 0; i = 0; x = 0; end
    @(negedge clk);
    addr_valid_i = 0;
    chk(hit_o === h, {req, " hit"}, 32'(hit_o), 32'(h));
    chk(win_idx_o === i, {req, " idx"}, 32'(win_idx_o), 32'(i));
    chk(xlat_addr_o === x, {req, " xlat"}, xlat_addr_o, x);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 3; k++) mdl[k] = 32'h000F_0000;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    rd(8'h50, "R1"); rd(8'h54, "R1"); rd(8'h58, "R1");
    chk(hit_o === 1'b0, "R1 hit_o", 32'(hit_o), 0);
    probe(32'h0000_0000, 1, "R1 disabled");
    // R2 field capture
    wr(8'h50, 32'h1234_5678); rd(8'h50, "R2");
    chk(cfg_rdata_o === 32'h1234_0000, "R2 fields", cfg_rdata_o, 32'h1234_0000);
    // R3 other offsets ignored
    wr(8'h5C, 32'hFFFF_FFFF); wr(8'h52, 32'hABCD_0000); wr(8'h4C, 32'h5555_0000);
    rd(8'h5C, "R3"); rd(8'h52, "R3"); rd(8'h50, "R3"); rd(8'h54, "R3"); rd(8'h58, "R3");
    // R4/R5 16 MB window at 0x12000000, base bits 23..20 ignored
    probe(32'h1200_0000, 1, "R4 low edge");
    probe(32'h12FF_FFFF, 1, "R5 top edge");
    probe(32'h1300_0000, 1, "R9 past edge");
    probe(32'h11FF_FFFF, 1, "R9 below");
    // R7 overlap
    wr(8'h54, 32'h1200_0000);
    probe(32'h1200_0010, 1, "R7 overlap");
    chk(win_idx_o === 2'd0, "R7 lowest wins", 32'(win_idx_o), 0);
    // R6 disable window 0
    wr(8'h50, 32'h120C_0000);
    probe(32'h1200_0010, 1, "R6 code C");
    chk(win_idx_o === 2'd1, "R6 falls to w1", 32'(win_idx_o), 1);
    probe(32'h1250_0000, 1, "R6 disabled miss");
    // R5 2 GB window
    wr(8'h58, 32'h800B_0000);
    probe(32'hFFFF_FFFF, 1, "R5 2GB");
    probe(32'h7FFF_FFFF, 1, "R5 2GB miss");
    // R8 no strobe
    probe(32'h1200_0010, 0, "R8 no valid");
    chk(hit_o === 1'b0, "R8", 32'(hit_o), 0);
    // random
    for (int it = 0; it < 3000; it++) begin
      if ($urandom_range(0, 9) == 0) begin
        logic [31:0] d;
        d = $urandom();
        if ($urandom_range(0, 3) != 0) d[19:16] = 4'($urandom_range(0, 11));
        else d[19:16] = 4'($urandom_range(0, 15));
        if ($urandom_range(0, 2) == 0) d[19:16] = 4'($urandom_range(0, 3));
        wr(8'(8'h50 + 4 * $urandom_range(0, 3)), d);
        rd(8'(8'h50 + 4 * $urandom_range(0, 3)), "R2 rand");
      end else begin
        logic [31:0] a;
        int k;
        a = $urandom();
        k = $urandom_range(0, 2);
        if ($urandom_range(0, 1) == 0) a[31:20] = mdl[k][31:20] ^ 12'($urandom_range(0, 3));
        probe(a, $urandom_range(0, 7) != 0, "R4 R5 R7 rand");
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule